// File: doc/BRIEF.md
# Escalating Watchdog Timer with Write Lock

This block is a bus-mapped watchdog. Software loads a period and sets the run bit. A down-counter then steps once per clock. When the count hits zero the counter refills from the period register and a timeout flag is raised. The flag drives an interrupt line, gated by the run bit. If the flag is still pending when the count reaches zero again and reset escalation is enabled, the block emits a one-clock reset request. The chip's reset logic acts on that request.

Software keeps the system alive by clearing the flag before the second timeout. It can also rewrite the period, which refills the running counter at once. A lock register protects the configuration. Any write to it engages the lock, except a write of the unlock key. While the lock is engaged, writes to the period and control registers are dropped. A stall bit freezes the counter while a debug-halt input is high.

All registers sit on a simple register bus: a word address, a write strobe, write data, and read data that is registered one cycle later. Reset is synchronous and active-high.

Top module: `wdog_top`

## Requirements
- R1: After reset the period register and the counter read all ones. The control register reads 0, the lock reads 0 (released), and `irq_o` and `sys_rst_req_o` are low.
- R2: Address map (word index): 0 period, 1 counter (read-only), 2 control, 3 raw flag, 4 masked flag, 5 flag clear, 6 stall, 7 lock. Read data for the address presented at a clock edge appears on `bus_rdata` after that edge, and not before it.
- R3: Control bit 0 is the run bit. Setting it from 0 copies the period into the counter. From then on the counter drops by one per clock. A counter at 0 refills from the period and sets the raw flag, so the flag is set L+1 clocks after the enabling write for period L.
- R4: Control bit 1 enables escalation. With it set, the second timeout pulses `sys_rst_req_o` for exactly one clock, L+1 clocks after the first timeout, provided the raw flag was still set.
- R5: With control bit 1 clear, no reset request is ever issued, even though the flag stays pending.
- R6: Writing a value with bit 0 set to the clear address drops the raw flag. A cleared flag prevents the reset request at the next timeout, and that timeout sets the flag again.
- R7: A write of any value other than the key 0x1ACCE551 to the lock address engages the lock, and the lock then reads 1. While the lock is engaged, period and control writes have no effect. Writing the key releases the lock, and it then reads 0.
- R8: A period write while running loads the written value into the counter at the same clock edge.
- R9: A period write of 0 sets the raw flag at once, even when the watchdog is not running.
- R10: The masked flag (address 4) and `irq_o` are the raw flag ANDed with the run bit.
- R11: When the stall bit (address 6, bit 0) is 1 and `dbg_halt` is high, the counter holds. When the stall bit is 0, `dbg_halt` is ignored.
- R12: Once set, the run bit stays set until reset. A control write with bit 0 clear leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dbg_halt | input | 1 | Processor halted by debugger |
| irq_o | output | 1 | Timeout interrupt (masked flag) |
| sys_rst_req_o | output | 1 | One-clock reset request |

## Verification
A write lands at the clock edge where the strobe is seen. Read data shows the addressed value one edge later. The flag and `irq_o` rise L+1 edges after the enabling write. The reset pulse comes a further L+1 edges after that and lasts one clock. The bench always drives the bus at falling edges and samples at the next falling edge, so every check falls half a cycle after the edge it targets. It samples one clock before and exactly at each due cycle, which catches a result that comes early, late or with the wrong width.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PERIOD = 3'd0,
    A_COUNT  = 3'd1,
    A_CTRL   = 3'd2,
    A_RAW    = 3'd3,
    A_MASKED = 3'd4,
    A_CLEAR  = 3'd5,
    A_STALL  = 3'd6,
    A_LOCK   = 3'd7
  } wd_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_ESC_BIT = 1;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         hold,
  input  logic         force_ld,
  input  logic [W-1:0] force_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] count_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ZERO     = '0;

  logic [W-1:0] cnt_q;
  logic         step;

  assign step     = run & ~hold & ~force_ld;
  assign expire_o = step & (cnt_q == ZERO);
  assign count_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ALL_ONES;
    end else if (force_ld) begin
      cnt_q <= force_val;
    end else if (step) begin
      if (cnt_q == ZERO) cnt_q <= reload_val;
      else               cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_lock.sv
module wdog_lock #(
  parameter int          W   = 32,
  parameter logic [31:0] KEY = 32'h1ACC_E551
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         locked_o
);
  localparam logic [W-1:0] KEY_W = KEY[W-1:0];

  logic locked_q;
  assign locked_o = locked_q;

  always_ff @(posedge clk) begin
    if (rst)     locked_q <= 1'b0;
    else if (wr) locked_q <= (wdata != KEY_W);
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic zero_load,
  input  logic clr,
  input  logic esc_en,
  output logic raw_o,
  output logic req_o
);
  logic raw_q;
  logic req_q;

  assign raw_o = raw_q;
  assign req_o = req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (expire || zero_load) raw_q <= 1'b1;
      else if (clr)            raw_q <= 1'b0;
      req_q <= expire & raw_q & esc_en;
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter logic [31:0] UNLOCK_KEY  = 32'h1ACC_E551,
  parameter int          LOCKED_CODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] ZERO     = '0;
  localparam logic [DATA_W-1:0] LOCK_RD  = DATA_W'(LOCKED_CODE);

  logic [DATA_W-1:0] period_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] force_val;
  logic ie_q, esc_q, stall_q;
  logic locked, raw, expire;
  logic cfg_ok, wr_period, wr_ctrl, wr_lock, wr_stall, clr;
  logic start, force_ld, hold, zero_load;

  assign cfg_ok    = bus_we & ~locked;
  assign wr_period = cfg_ok & (bus_addr == A_PERIOD);
  assign wr_ctrl   = cfg_ok & (bus_addr == A_CTRL);
  assign wr_lock   = bus_we & (bus_addr == A_LOCK);
  assign wr_stall  = bus_we & (bus_addr == A_STALL);
  assign clr       = bus_we & (bus_addr == A_CLEAR) & bus_wdata[0];
  assign start     = wr_ctrl & bus_wdata[CTRL_RUN_BIT] & ~ie_q;
  assign force_ld  = (wr_period & ie_q) | start;
  assign force_val = wr_period ? bus_wdata : period_q;
  assign hold      = stall_q & dbg_halt;
  assign zero_load = wr_period & (bus_wdata == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= ALL_ONES;
      ie_q     <= 1'b0;
      esc_q    <= 1'b0;
      stall_q  <= 1'b0;
    end else begin
      if (wr_period) period_q <= bus_wdata;
      if (wr_ctrl) begin
        ie_q  <= ie_q | bus_wdata[CTRL_RUN_BIT];
        esc_q <= bus_wdata[CTRL_ESC_BIT];
      end
      if (wr_stall) stall_q <= bus_wdata[0];
    end
  end

  wdog_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ie_q), .hold(hold),
    .force_ld(force_ld), .force_val(force_val), .reload_val(period_q),
    .count_o(count), .expire_o(expire)
  );

  wdog_lock #(.W(DATA_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk(clk), .rst(rst), .wr(wr_lock), .wdata(bus_wdata), .locked_o(locked)
  );

  wdog_status u_stat (
    .clk(clk), .rst(rst), .expire(expire), .zero_load(zero_load),
    .clr(clr), .esc_en(esc_q), .raw_o(raw), .req_o(sys_rst_req_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= ZERO;
    end else begin
      case (bus_addr)
        A_PERIOD: rdata_q <= period_q;
        A_COUNT:  rdata_q <= count;
        A_CTRL:   rdata_q <= {{(DATA_W-2){1'b0}}, esc_q, ie_q};
        A_RAW:    rdata_q <= {{(DATA_W-1){1'b0}}, raw};
        A_MASKED: rdata_q <= {{(DATA_W-1){1'b0}}, raw & ie_q};
        A_LOCK:   rdata_q <= locked ? LOCK_RD : ZERO;
        default:  rdata_q <= ZERO;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = raw & ie_q;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              dbg_halt,
  input logic              sys_rst_req_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] period_q,
  input logic [DATA_W-1:0] count,
  input logic              ie_q,
  input logic              esc_q,
  input logic              stall_q,
  input logic              locked,
  input logic              raw
);
  // R12: run bit never falls outside reset
  a_r12_run_sticky: assert property (@(posedge clk) disable iff (rst)
    ie_q |=> ie_q);

  // R7: locked period write leaves the period unchanged
  a_r7_locked_period: assert property (@(posedge clk) disable iff (rst)
    (locked && bus_we && bus_addr == A_PERIOD) |=> $stable(period_q));

  // R11: stalled counter holds when no period write is present
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (ie_q && stall_q && dbg_halt && !(bus_we && bus_addr inside {A_PERIOD, A_CTRL}))
      |=> $stable(count));

  // R5: no reset request without escalation enabled
  a_r5_no_escalation: assert property (@(posedge clk) disable iff (rst)
    !esc_q |=> !sys_rst_req_o);

  // R4: a reset request follows a pending flag at the prior clock
  a_r4_req_needs_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req_o) |-> $past(raw));

  // R3: running counter without stall or writes steps down by one
  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (ie_q && !(stall_q && dbg_halt) && count != '0 && !bus_we)
      |=> count == $past(count) - 1'b1);

  // R10: interrupt never asserted while not running
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !ie_q |-> !irq_o);
endmodule

bind wdog_top wdog_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .dbg_halt(dbg_halt), .sys_rst_req_o(sys_rst_req_o), .irq_o(irq_o),
  .period_q(period_q), .count(count), .ie_q(ie_q), .esc_q(esc_q),
  .stall_q(stall_q), .locked(locked), .raw(raw)
);

// File: tb/wdog_top_tb.sv
`timescale 1ns/1ps
module wdog_top_tb;
  import wdog_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              dbg_halt = 1'b0;
  logic              irq_o, sys_rst_req_o;

  int nchk = 0;
  int nerr = 0;

  localparam logic [31:0] KEY = 32'h1ACC_E551;

  // period, escalation enable, expected reset pulse
  localparam int NVEC = 4;
  localparam logic [33:0] VEC [NVEC] = '{
    {32'd3, 1'b1, 1'b1},
    {32'd5, 1'b0, 1'b0},
    {32'd1, 1'b1, 1'b1},
    {32'd8, 1'b1, 1'b1}
  };

  always #2 clk = ~clk;

  wdog_top u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
    .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 req", {31'd0, sys_rst_req_o}, 32'd0);
    rd(A_PERIOD, v); check("R1 period", v, 32'hFFFF_FFFF);
    rd(A_COUNT, v);  check("R1 count", v, 32'hFFFF_FFFF);
    rd(A_LOCK, v);   check("R1 lock", v, 32'd0);
    rd(A_CTRL, v);   check("R1 ctrl", v, 32'd0);

    // R2 read data appears only after the edge
    bus_addr = A_PERIOD;
    #1 check("R2 before edge", bus_rdata, 32'd0);
    @(negedge clk);
    check("R2 after edge", bus_rdata, 32'hFFFF_FFFF);

    // R3 R4 R5 vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] per;
      logic        esc, exp_req;
      {per, esc, exp_req} = VEC[i];
      do_reset();
      wr(A_PERIOD, per);
      wr(A_CTRL, {30'd0, esc, 1'b1});
      repeat (per) @(negedge clk);
      check("R3 no flag before due", {31'd0, irq_o}, 32'd0);
      @(negedge clk);
      check("R3 flag at L+1", {31'd0, irq_o}, 32'd1);
      repeat (per) @(negedge clk);
      check("R4 no early request", {31'd0, sys_rst_req_o}, 32'd0);
      @(negedge clk);
      check(exp_req ? "R4 reset pulse" : "R5 no reset",
            {31'd0, sys_rst_req_o}, {31'd0, exp_req});
      @(negedge clk);
      check("R4 pulse one clock", {31'd0, sys_rst_req_o}, 32'd0);
    end

    // R6 clear prevents escalation
    do_reset();
    wr(A_PERIOD, 32'd6);
    wr(A_CTRL, 32'd3);
    repeat (7) @(negedge clk);
    check("R6 flag set", {31'd0, irq_o}, 32'd1);
    wr(A_CLEAR, 32'd1);
    check("R6 flag cleared", {31'd0, irq_o}, 32'd0);
    repeat (6) @(negedge clk);
    check("R6 no reset after clear", {31'd0, sys_rst_req_o}, 32'd0);
    check("R6 flag re-set", {31'd0, irq_o}, 32'd1);

    // R8 period write while running
    do_reset();
    wr(A_PERIOD, 32'd1000);
    wr(A_CTRL, 32'd1);
    repeat (3) @(negedge clk);
    wr(A_PERIOD, 32'd200);
    rd(A_COUNT, v);
    check("R8 immediate load", v, 32'd200);

    // R11 stall
    wr(A_STALL, 32'd1);
    dbg_halt = 1'b1;
    rd(A_COUNT, v);
    repeat (4) @(negedge clk);
    rd(A_COUNT, v2);
    check("R11 held while halted", v2, v);
    dbg_halt = 1'b0;
    rd(A_COUNT, v);
    repeat (4) @(negedge clk);
    rd(A_COUNT, v2);
    check("R11 runs after release", v2, v - 32'd5);
    wr(A_STALL, 32'd0);
    dbg_halt = 1'b1;
    rd(A_COUNT, v);
    repeat (4) @(negedge clk);
    rd(A_COUNT, v2);
    check("R11 halt ignored without stall", v2, v - 32'd5);
    dbg_halt = 1'b0;

    // R12 run bit sticky
    wr(A_CTRL, 32'd0);
    rd(A_CTRL, v);
    check("R12 run stays", v, 32'd1);

    // R7 lock
    wr(A_LOCK, 32'h55);
    rd(A_LOCK, v);   check("R7 locked reads 1", v, 32'd1);
    wr(A_PERIOD, 32'd7);
    rd(A_PERIOD, v); check("R7 period write ignored", v, 32'd200);
    wr(A_CTRL, 32'd2);
    rd(A_CTRL, v);   check("R7 ctrl write ignored", v, 32'd1);
    wr(A_LOCK, KEY);
    rd(A_LOCK, v);   check("R7 key unlocks", v, 32'd0);
    wr(A_PERIOD, 32'd300);
    rd(A_PERIOD, v); check("R7 write after unlock", v, 32'd300);

    // R9 R10 zero period while stopped, then masked
    do_reset();
    wr(A_PERIOD, 32'd0);
    rd(A_RAW, v);    check("R9 zero sets flag", v, 32'd1);
    rd(A_MASKED, v); check("R10 masked off", v, 32'd0);
    check("R10 irq off", {31'd0, irq_o}, 32'd0);
    wr(A_CTRL, 32'd1);
    rd(A_MASKED, v); check("R10 masked on", v, 32'd1);
    check("R10 irq on", {31'd0, irq_o}, 32'd1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule